// File: doc/BRIEF.md
# Dual-Bus Command and Event Mailbox

This block is the register window between a host processor and a coprocessor that runs two I2C buses. The host owns a plain 32-bit register bus. To start an operation it writes a command word into the command slot for one bus. The coprocessor gets a one-cycle strobe that carries the word, its decoded fields and the bus it came from. Both buses share one area of eight data words. A short transfer of up to 32 bytes keeps its payload in those words. A longer transfer instead places a 64-bit buffer address in the first two words, which the block presents to the coprocessor as one value.

When an operation finishes, the coprocessor posts an event word for the bus concerned. The post also sets the interrupt-generate register to 1, and that drives a level interrupt toward the host. The host reads the event, writes zero to the event slot to consume it, and writes zero to the interrupt-generate register to drop the line. That last step also clears an interrupt that was raised with no event behind it. A read-only status word lists which events are pending. A debug word written by the coprocessor can be read by the host.

Top module: `dual_cmd_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every mapped register reads zero, `host_irq` is low and `cp_cmd_valid` is low.
- R2: A host write to offset 0x00 (bus 0) or 0x04 (bus 1) stores the word, which can then be read back. In the cycle after the write edge, `cp_cmd_valid` is high for exactly one cycle, with `cp_cmd_bus` set to the bus of the written offset and `cp_cmd_word` set to the written word.
- R3: During the strobe, the command fields are decoded from the word as: operation bits 3:0, target address bits 15:8, length bits 27:16, speed code bits 30:28, placement flag bit 31 (1 means the payload is in the data words).
- R4: During the strobe, `cp_buf_addr` is {data word 1, data word 0} when bit 31 of the command is 0, and zero when it is 1.
- R5: Data word i lives at byte offset 0x08 + 4*i (i = 0..7). The host can read and write it, and the coprocessor can read it and write it through its index port. If both sides write the same word in the same cycle, the coprocessor value is kept.
- R6: A coprocessor event post loads the event register of the selected bus (bus 0 at 0x184, bus 1 at 0x188) and sets the interrupt-generate register (0x190) to 1. From the next cycle `host_irq` is high.
- R7: A host write to an event register stores the written value, so writing zero consumes the event. A post to the same register in the same cycle wins over the host write.
- R8: `host_irq` is high exactly while 0x190 is nonzero. A host write to 0x190 stores the written value, even when both event registers are zero. A post in the same cycle wins, leaving 1.
- R9: The status word at 0x194 has bit 0 set when event 0 is nonzero, bit 1 set when event 1 is nonzero, bit 2 set when 0x190 is nonzero, and all other bits zero.
- R10: Reads of 0x180 and of any unmapped offset return zero. Host writes to 0x180, 0x18C, 0x194 or an unmapped offset change no register.
- R11: The debug word at 0x18C is loaded by the coprocessor debug write port, and the host can read it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr_en | input | 1 | Host write strobe |
| h_addr | input | HADDR_W | Host byte offset for reads and writes |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr (combinational) |
| host_irq | output | 1 | Level interrupt toward the host |
| cp_cmd_valid | output | 1 | One-cycle new-command strobe |
| cp_cmd_bus | output | 1 | Bus the command was written for |
| cp_cmd_word | output | 32 | Full command word |
| cp_cmd_op | output | 4 | Decoded operation |
| cp_cmd_target | output | 8 | Decoded target address |
| cp_cmd_len | output | 12 | Decoded length |
| cp_cmd_speed | output | 3 | Decoded speed code |
| cp_cmd_inline | output | 1 | Payload is in the data words |
| cp_buf_addr | output | 64 | External buffer address, or zero for inline |
| cp_data_idx | input | $clog2(DATA_WORDS) | Coprocessor data word index |
| cp_data_rdata | output | 32 | Data word at cp_data_idx |
| cp_data_we | input | 1 | Coprocessor data word write |
| cp_data_wdata | input | 32 | Coprocessor data word write value |
| cp_evt_valid | input | 1 | Coprocessor event post |
| cp_evt_bus | input | 1 | Bus of the posted event |
| cp_evt_word | input | 32 | Event word |
| cp_dbg_we | input | 1 | Coprocessor debug word write |
| cp_dbg_wdata | input | 32 | Debug word value |

## Verification
A stuck or misrouted command register shows up in the strobe that follows the write, one cycle later, as a wrong word, wrong bus or wrong decoded field. The scoreboard compares every strobe against the queued expectation, and it also treats an extra strobe or a strobe longer than one cycle as an error. A wrong event or interrupt-generate state appears at once in the combinational host readback and in the status bits. It also reaches `host_irq` in the cycle after the post or clear, so each post and acknowledge is followed by a read of both slots, the status word and the interrupt line. The collision cases make the post-wins ordering visible at the ports in the cycle after the shared edge.

// File: rtl/mbx_pkg.sv
// Package: register offsets and command field positions of the mailbox.
// Assumes byte offsets on a word-aligned host register bus.
package mbx_pkg;
    localparam int REG_W        = 32;
    localparam int NUM_BUS      = 2;
    localparam int OFS_CMD0     = 'h000;
    localparam int OFS_CMD1     = 'h004;
    localparam int OFS_DATA0    = 'h008;
    localparam int OFS_RSVD     = 'h180;
    localparam int OFS_EVT0     = 'h184;
    localparam int OFS_EVT1     = 'h188;
    localparam int OFS_DBG      = 'h18C;
    localparam int OFS_IRQ_GEN  = 'h190;
    localparam int OFS_IRQ_STAT = 'h194;
    // command word field positions
    localparam int CF_OP_LSB    = 0;
    localparam int CF_TGT_LSB   = 8;
    localparam int CF_LEN_LSB   = 16;
    localparam int CF_SPD_LSB   = 28;
    localparam int CF_INLINE    = 31;
endpackage

// File: rtl/mbx_cmd_regs.sv
// Per-bus command registers and the command strobe.
// Assumes at most one host write per cycle; wr_idx selects the bus slot.
module mbx_cmd_regs #(
    parameter int NUM_BUS = 2,
    parameter int W       = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_BUS)-1:0]          wr_idx,
    input  logic [W-1:0]                        wdata,
    output logic [NUM_BUS-1:0][W-1:0]           cmd_q,
    output logic                                pulse,
    output logic [$clog2(NUM_BUS)-1:0]          pulse_bus
);
    localparam int BUS_W = $clog2(NUM_BUS);

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_slot
        // Hold the last command written for bus b.
        always_ff @(posedge clk) begin
            if (!rst_n)                              cmd_q[b] <= '0;
            else if (wr_en && wr_idx == BUS_W'(b))   cmd_q[b] <= wdata;
        end
    end

    // Raise the strobe for one cycle after each command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse     <= 1'b0;
            pulse_bus <= '0;
        end else begin
            pulse     <= wr_en;
            pulse_bus <= wr_idx;
        end
    end

    a_r2_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(wr_en));
    a_r2_pulse_word: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> cmd_q[pulse_bus] == $past(wdata));
endmodule

// File: rtl/mbx_data_area.sv
// Shared data words, written by both the host and the coprocessor.
// Assumes the coprocessor write wins on a same-word collision.
module mbx_data_area #(
    parameter int WORDS = 8,
    parameter int W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic [$clog2(WORDS)-1:0]      host_idx,
    input  logic [W-1:0]                  host_wdata,
    input  logic                          cp_we,
    input  logic [$clog2(WORDS)-1:0]      cp_idx,
    input  logic [W-1:0]                  cp_wdata,
    output logic [WORDS-1:0][W-1:0]       words
);
    localparam int IDX_W = $clog2(WORDS);

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Update word i, coprocessor first.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  words[i] <= '0;
            else if (cp_we && cp_idx == IDX_W'(i))       words[i] <= cp_wdata;
            else if (host_we && host_idx == IDX_W'(i))   words[i] <= host_wdata;
        end
    end

    a_r5_cp_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cp_we |=> words[$past(cp_idx)] == $past(cp_wdata));
endmodule

// File: rtl/mbx_event_irq.sv
// Event registers, interrupt-generate register and debug word.
// Assumes a coprocessor post wins over a host write to the same register.
module mbx_event_irq #(
    parameter int NUM_BUS = 2,
    parameter int W       = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_evt_we,
    input  logic [$clog2(NUM_BUS)-1:0]    host_evt_idx,
    input  logic                          host_gen_we,
    input  logic [W-1:0]                  host_wdata,
    input  logic                          post_valid,
    input  logic [$clog2(NUM_BUS)-1:0]    post_bus,
    input  logic [W-1:0]                  post_word,
    input  logic                          dbg_we,
    input  logic [W-1:0]                  dbg_wdata,
    output logic [NUM_BUS-1:0][W-1:0]     evt_q,
    output logic [W-1:0]                  gen_q,
    output logic [W-1:0]                  dbg_q,
    output logic                          irq
);
    localparam int BUS_W = $clog2(NUM_BUS);

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_evt
        // Load a posted event, else take the host write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                          evt_q[b] <= '0;
            else if (post_valid && post_bus == BUS_W'(b))        evt_q[b] <= post_word;
            else if (host_evt_we && host_evt_idx == BUS_W'(b))   evt_q[b] <= host_wdata;
        end
    end

    // Set interrupt-generate on a post, else take the host write.
    always_ff @(posedge clk) begin
        if (!rst_n)           gen_q <= '0;
        else if (post_valid)  gen_q <= W'(1);
        else if (host_gen_we) gen_q <= host_wdata;
    end

    // Capture the coprocessor debug word.
    always_ff @(posedge clk) begin
        if (!rst_n)      dbg_q <= '0;
        else if (dbg_we) dbg_q <= dbg_wdata;
    end

    assign irq = |gen_q;

    a_r6_post_loads: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> evt_q[$past(post_bus)] == $past(post_word) && gen_q == W'(1));
    a_r6_irq_after_post: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> irq);
    a_r7_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_valid && !host_evt_we) |=> $stable(evt_q));
    a_r8_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_valid && !host_gen_we) |=> $stable(gen_q));
endmodule

// File: rtl/dual_cmd_mailbox.sv
// Top: host address decode, readback mux, command field decode and
// buffer address presentation. Assumes DATA_WORDS >= 2 and that the data
// area ends below the event block.
module dual_cmd_mailbox #(
    parameter int DATA_WORDS = 8,
    parameter int HADDR_W    = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            h_wr_en,
    input  logic [HADDR_W-1:0]              h_addr,
    input  logic [31:0]                     h_wdata,
    output logic [31:0]                     h_rdata,
    output logic                            host_irq,
    output logic                            cp_cmd_valid,
    output logic                            cp_cmd_bus,
    output logic [31:0]                     cp_cmd_word,
    output logic [3:0]                      cp_cmd_op,
    output logic [7:0]                      cp_cmd_target,
    output logic [11:0]                     cp_cmd_len,
    output logic [2:0]                      cp_cmd_speed,
    output logic                            cp_cmd_inline,
    output logic [63:0]                     cp_buf_addr,
    input  logic [$clog2(DATA_WORDS)-1:0]   cp_data_idx,
    output logic [31:0]                     cp_data_rdata,
    input  logic                            cp_data_we,
    input  logic [31:0]                     cp_data_wdata,
    input  logic                            cp_evt_valid,
    input  logic                            cp_evt_bus,
    input  logic [31:0]                     cp_evt_word,
    input  logic                            cp_dbg_we,
    input  logic [31:0]                     cp_dbg_wdata
);
    import mbx_pkg::*;
    localparam int IDX_W    = $clog2(DATA_WORDS);
    localparam int DATA_END = OFS_DATA0 + 4 * DATA_WORDS;

    logic [NUM_BUS-1:0][REG_W-1:0]    cmd_q;
    logic [DATA_WORDS-1:0][REG_W-1:0] words;
    logic [NUM_BUS-1:0][REG_W-1:0]    evt_q;
    logic [REG_W-1:0]                 gen_q, dbg_q;
    logic cmd_hit, data_hit, evt_hit, gen_hit, dbg_hit, stat_hit;
    logic cmd_idx, evt_idx;
    logic [HADDR_W-1:0] data_ofs;
    logic [IDX_W-1:0]   data_idx;

    // Decode the host offset into register selects.
    always_comb begin
        cmd_hit  = (h_addr == HADDR_W'(OFS_CMD0)) || (h_addr == HADDR_W'(OFS_CMD1));
        cmd_idx  = (h_addr == HADDR_W'(OFS_CMD1));
        data_ofs = h_addr - HADDR_W'(OFS_DATA0);
        data_hit = (int'(h_addr) >= OFS_DATA0) && (int'(h_addr) < DATA_END)
                   && (h_addr[1:0] == 2'b00);
        data_idx = IDX_W'(data_ofs >> 2);
        evt_hit  = (h_addr == HADDR_W'(OFS_EVT0)) || (h_addr == HADDR_W'(OFS_EVT1));
        evt_idx  = (h_addr == HADDR_W'(OFS_EVT1));
        gen_hit  = (h_addr == HADDR_W'(OFS_IRQ_GEN));
        dbg_hit  = (h_addr == HADDR_W'(OFS_DBG));
        stat_hit = (h_addr == HADDR_W'(OFS_IRQ_STAT));
    end

    mbx_cmd_regs #(.NUM_BUS(NUM_BUS), .W(REG_W)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .wr_en(h_wr_en && cmd_hit), .wr_idx(cmd_idx), .wdata(h_wdata),
        .cmd_q(cmd_q), .pulse(cp_cmd_valid), .pulse_bus(cp_cmd_bus)
    );

    mbx_data_area #(.WORDS(DATA_WORDS), .W(REG_W)) u_data (
        .clk(clk), .rst_n(rst_n),
        .host_we(h_wr_en && data_hit), .host_idx(data_idx), .host_wdata(h_wdata),
        .cp_we(cp_data_we), .cp_idx(cp_data_idx), .cp_wdata(cp_data_wdata),
        .words(words)
    );

    mbx_event_irq #(.NUM_BUS(NUM_BUS), .W(REG_W)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .host_evt_we(h_wr_en && evt_hit), .host_evt_idx(evt_idx),
        .host_gen_we(h_wr_en && gen_hit), .host_wdata(h_wdata),
        .post_valid(cp_evt_valid), .post_bus(cp_evt_bus), .post_word(cp_evt_word),
        .dbg_we(cp_dbg_we), .dbg_wdata(cp_dbg_wdata),
        .evt_q(evt_q), .gen_q(gen_q), .dbg_q(dbg_q), .irq(host_irq)
    );

    // Host readback; reserved and unmapped offsets read zero.
    always_comb begin
        h_rdata = '0;
        if (cmd_hit)       h_rdata = cmd_q[cmd_idx];
        else if (data_hit) h_rdata = words[data_idx];
        else if (evt_hit)  h_rdata = evt_q[evt_idx];
        else if (dbg_hit)  h_rdata = dbg_q;
        else if (gen_hit)  h_rdata = gen_q;
        else if (stat_hit) h_rdata = {29'd0, |gen_q, |evt_q[1], |evt_q[0]};
    end

    // Present the strobed command, its fields and the buffer address.
    always_comb begin
        cp_cmd_word   = cmd_q[cp_cmd_bus];
        cp_cmd_op     = cp_cmd_word[CF_OP_LSB +: 4];
        cp_cmd_target = cp_cmd_word[CF_TGT_LSB +: 8];
        cp_cmd_len    = cp_cmd_word[CF_LEN_LSB +: 12];
        cp_cmd_speed  = cp_cmd_word[CF_SPD_LSB +: 3];
        cp_cmd_inline = cp_cmd_word[CF_INLINE];
        cp_buf_addr   = cp_cmd_inline ? 64'd0 : {words[1], words[0]};
        cp_data_rdata = words[cp_data_idx];
    end

    a_r8_irq_follows_gen: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_en && gen_hit && !cp_evt_valid && h_wdata == 32'd0) |=> !host_irq);
endmodule

// File: tb/dual_cmd_mailbox_tb.sv
`timescale 1ns/1ps
module dual_cmd_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr_en = 1'b0;
    logic [8:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        host_irq, cp_cmd_valid, cp_cmd_bus, cp_cmd_inline;
    logic [31:0] cp_cmd_word, cp_data_rdata;
    logic [3:0]  cp_cmd_op;
    logic [7:0]  cp_cmd_target;
    logic [11:0] cp_cmd_len;
    logic [2:0]  cp_cmd_speed;
    logic [63:0] cp_buf_addr;
    logic [2:0]  cp_data_idx = '0;
    logic        cp_data_we = 1'b0;
    logic [31:0] cp_data_wdata = '0;
    logic        cp_evt_valid = 1'b0, cp_evt_bus = 1'b0;
    logic [31:0] cp_evt_word = '0;
    logic        cp_dbg_we = 1'b0;
    logic [31:0] cp_dbg_wdata = '0;

    int n_cmp = 0, n_bad = 0;
    logic [96:0] exp_q[$];   // {bus, word, buffer address}

    always #2.5 clk = ~clk;

    dual_cmd_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
        .cp_cmd_valid(cp_cmd_valid), .cp_cmd_bus(cp_cmd_bus), .cp_cmd_word(cp_cmd_word),
        .cp_cmd_op(cp_cmd_op), .cp_cmd_target(cp_cmd_target), .cp_cmd_len(cp_cmd_len),
        .cp_cmd_speed(cp_cmd_speed), .cp_cmd_inline(cp_cmd_inline),
        .cp_buf_addr(cp_buf_addr), .cp_data_idx(cp_data_idx),
        .cp_data_rdata(cp_data_rdata), .cp_data_we(cp_data_we),
        .cp_data_wdata(cp_data_wdata), .cp_evt_valid(cp_evt_valid),
        .cp_evt_bus(cp_evt_bus), .cp_evt_word(cp_evt_word),
        .cp_dbg_we(cp_dbg_we), .cp_dbg_wdata(cp_dbg_wdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic hwrite(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        h_wr_en = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        @(negedge clk);
        h_addr = a;
        #1;
        chk(req, h_rdata, exp);
    endtask

    // Driver: queue the expected strobe, then write the command slot.
    task automatic send_cmd(input logic bus, input logic [31:0] w, input logic [63:0] a);
        exp_q.push_back({bus, w, a});
        hwrite(bus ? 9'h004 : 9'h000, w);
        @(negedge clk);
        chk("R2 strobe lasts one cycle", cp_cmd_valid, 0);
    endtask

    task automatic post(input logic bus, input logic [31:0] w);
        @(negedge clk);
        cp_evt_valid = 1'b1; cp_evt_bus = bus; cp_evt_word = w;
        @(negedge clk);
        cp_evt_valid = 1'b0;
    endtask

    // Monitor: pop and compare each command strobe.
    always @(negedge clk) begin
        if (rst_n && cp_cmd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected strobe", 1, 0);
            end else begin
                logic [96:0] e;
                e = exp_q.pop_front();
                chk("R2 strobe bus", cp_cmd_bus, e[96]);
                chk("R2 strobe word", cp_cmd_word, e[95:64]);
                chk("R3 op field", cp_cmd_op, e[67:64]);
                chk("R3 target field", cp_cmd_target, e[79:72]);
                chk("R3 length field", cp_cmd_len, e[91:80]);
                chk("R3 speed field", cp_cmd_speed, e[94:92]);
                chk("R3 placement flag", cp_cmd_inline, e[95]);
                chk("R4 buffer address", cp_buf_addr, e[63:0]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] w_in, w_ex;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq low", host_irq, 0);
        chk("R1 strobe low", cp_cmd_valid, 0);
        for (int a = 0; a <= 'h24; a += 4) rd_chk("R1 reset value", 9'(a), 0);
        for (int a = 'h184; a <= 'h194; a += 4) rd_chk("R1 reset value", 9'(a), 0);

        // R5 host data words and coprocessor read port
        hwrite(9'h008, 32'h89AB_CDEF);
        hwrite(9'h00C, 32'h0123_4567);
        hwrite(9'h014, 32'hA5A5_0303);
        rd_chk("R5 host readback word0", 9'h008, 32'h89AB_CDEF);
        rd_chk("R5 host readback word3", 9'h014, 32'hA5A5_0303);
        cp_data_idx = 3'd3; #1;
        chk("R5 coprocessor read word3", cp_data_rdata, 32'hA5A5_0303);

        // R2 R3 R4 inline command on bus 0, external command on bus 1
        w_in = {1'b1, 3'd1, 12'd4, 8'h3A, 4'd0, 4'd1};
        send_cmd(1'b0, w_in, 64'd0);
        w_ex = {1'b0, 3'd2, 12'd100, 8'h50, 4'd1, 4'd0};
        send_cmd(1'b1, w_ex, 64'h0123_4567_89AB_CDEF);
        rd_chk("R2 readback bus0 slot", 9'h000, w_in);
        rd_chk("R2 readback bus1 slot", 9'h004, w_ex);

        // R5 coprocessor write, then same-word collision
        @(negedge clk);
        cp_data_we = 1'b1; cp_data_idx = 3'd5; cp_data_wdata = 32'h1111_2222;
        @(negedge clk);
        cp_data_we = 1'b1; cp_data_idx = 3'd7; cp_data_wdata = 32'hC0C0_C0C0;
        h_wr_en = 1'b1; h_addr = 9'h024; h_wdata = 32'h4444_4444;
        @(negedge clk);
        cp_data_we = 1'b0; h_wr_en = 1'b0;
        rd_chk("R5 coprocessor write word5", 9'h01C, 32'h1111_2222);
        rd_chk("R5 collision coprocessor wins", 9'h024, 32'hC0C0_C0C0);

        // R6 R9 event posts
        post(1'b0, 32'h0040_2005);
        chk("R6 irq after post", host_irq, 1);
        rd_chk("R6 event bus0", 9'h184, 32'h0040_2005);
        rd_chk("R6 generate set", 9'h190, 32'd1);
        rd_chk("R9 status bus0 pending", 9'h194, 32'h5);
        post(1'b1, 32'h0050_1109);
        rd_chk("R6 event bus1", 9'h188, 32'h0050_1109);
        rd_chk("R9 status both pending", 9'h194, 32'h7);

        // R7 R8 acknowledge
        hwrite(9'h184, 32'd0);
        hwrite(9'h188, 32'd0);
        rd_chk("R9 status only generate", 9'h194, 32'h4);
        chk("R8 irq held until generate cleared", host_irq, 1);
        hwrite(9'h190, 32'd0);
        chk("R8 irq dropped", host_irq, 0);
        rd_chk("R9 status clear", 9'h194, 32'h0);

        // R8 spurious generate with no event
        hwrite(9'h190, 32'd1);
        chk("R8 spurious irq raised", host_irq, 1);
        rd_chk("R9 spurious status", 9'h194, 32'h4);
        hwrite(9'h190, 32'd0);
        chk("R8 spurious irq cleared", host_irq, 0);

        // R7 host value stored
        hwrite(9'h188, 32'h0000_0055);
        rd_chk("R7 host write stored", 9'h188, 32'h0000_0055);
        hwrite(9'h188, 32'd0);

        // R7 R8 post wins over simultaneous host write
        @(negedge clk);
        cp_evt_valid = 1'b1; cp_evt_bus = 1'b0; cp_evt_word = 32'h00AB_0001;
        h_wr_en = 1'b1; h_addr = 9'h184; h_wdata = 32'd0;
        @(negedge clk);
        cp_evt_valid = 1'b0; h_wr_en = 1'b0;
        rd_chk("R7 post wins on event slot", 9'h184, 32'h00AB_0001);
        hwrite(9'h184, 32'd0);
        @(negedge clk);
        cp_evt_valid = 1'b1; cp_evt_bus = 1'b1; cp_evt_word = 32'h00CD_0001;
        h_wr_en = 1'b1; h_addr = 9'h190; h_wdata = 32'd0;
        @(negedge clk);
        cp_evt_valid = 1'b0; h_wr_en = 1'b0;
        chk("R8 post wins on generate", host_irq, 1);
        rd_chk("R8 generate stays one", 9'h190, 32'd1);

        // R11 debug word
        @(negedge clk);
        cp_dbg_we = 1'b1; cp_dbg_wdata = 32'hDEB0_0001;
        @(negedge clk);
        cp_dbg_we = 1'b0;
        rd_chk("R11 debug readback", 9'h18C, 32'hDEB0_0001);

        // R10 unmapped and read-only offsets
        rd_chk("R10 past data area", 9'h028, 0);
        rd_chk("R10 reserved slot", 9'h180, 0);
        rd_chk("R10 unmapped high", 9'h1FC, 0);
        hwrite(9'h180, 32'hFFFF_FFFF);
        hwrite(9'h18C, 32'hFFFF_FFFF);
        hwrite(9'h194, 32'hFFFF_FFFF);
        hwrite(9'h100, 32'hFFFF_FFFF);
        rd_chk("R10 reserved still zero", 9'h180, 0);
        rd_chk("R10 debug untouched by host", 9'h18C, 32'hDEB0_0001);
        rd_chk("R10 status untouched", 9'h194, 32'h6);
        rd_chk("R10 unmapped still zero", 9'h100, 0);
        rd_chk("R10 data untouched", 9'h024, 32'hC0C0_C0C0);
        chk("R10 no stray strobe", cp_cmd_valid, 0);

        repeat (2) @(negedge clk);
        chk("R2 all strobes seen", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule